// File: doc/BRIEF.md
# Saturating Doubling Multiply Unit

This block is a lane-parallel signed multiplier for SIMD datapaths. Every lane forms twice the product of two signed elements, 16 or 32 bits wide, in one of four operations. Three are widening operations: a plain doubling multiply, a doubling multiply added to a double-width accumulator, and a doubling multiply subtracted from one. The fourth is a rounding doubling multiply that returns the high half of each element. The widening operations take their elements from the lower or upper half of the source vectors. A scalar form is lane 0 of the same datapath.

Any clipping sets a sticky saturation flag. Clipping can come from the doubled product, from the accumulate step, or from the rounded high half. The flag stays set until software clears it. Results appear one clock after an accepted operation, together with a valid strobe.

Top module: `sdm_unit`

## Requirements
- R1: With `esize`=0 and `mode`=0, each 32-bit destination lane i, at bits [32i+31:32i], holds the exact value 2·a·b. The operands a and b are the signed 16-bit elements i of the selected source half.
- R2: With `esize`=1 and `mode`=0, each 64-bit destination lane i holds the exact value 2·a·b of the signed 32-bit elements i of the selected half.
- R3: In modes 0 to 2, `hi_sel`=0 selects source bits [VEC_W/2-1:0] and `hi_sel`=1 selects the upper half.
- R4: When both elements equal the most negative element value, the doubled product becomes the largest positive double-width value and the flag is set.
- R5: Element pairs whose doubled product fits produce exact results and leave the flag unchanged. This includes half of the most negative value times the most negative value.
- R6: In `mode`=1, each lane returns accumulator + doubled product. The sum saturates to the double-width maximum or minimum, and an overflow sets the flag.
- R7: In `mode`=2, each lane returns accumulator − doubled product, saturated the same way, and an overflow sets the flag.
- R8: In `mode`=3, every element position of the full source vectors returns (2·a·b + 2^(n−1)) >> n, where n is the element width.
- R9: In `mode`=3, a most-negative × most-negative pair returns the largest positive element value and sets the flag.
- R10: `out_valid` rises exactly one cycle after `in_valid`. `out_res` keeps its value while no operation is accepted.
- R11: `sat_flag` stays set until `sat_clr` is asserted. When `sat_clr` and a saturating operation arrive in the same cycle, the flag stays set.
- R12: Reset clears `out_valid`, `out_res` and `sat_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation accepted this cycle |
| mode | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 rounding high half |
| esize | input | 1 | Element width: 0 = 16 bits, 1 = 32 bits |
| hi_sel | input | 1 | Source half for the widening modes |
| src_a | input | VEC_W | First operand vector |
| src_b | input | VEC_W | Second operand vector |
| acc_in | input | VEC_W | Double-width accumulator lanes |
| sat_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result valid |
| out_res | output | VEC_W | Result lanes |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Random operands in all four modes and both widths check the general arithmetic. Random operands seldom reach the extremes, so some random operations force a most-negative × most-negative pair into lane 0. Separate directed cases then split three kinds of pair. The first is the real overflow pair, which must clip. The second is half-most-negative × most-negative, which must stay exact. The third is the pair one step above the most negative value, which shows whether rounding lands correctly just below the limit. Accumulators near both ends of the range show apart add and subtract overflow. The sign of each clamp shows whether it is chosen from the accumulator or from the product.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  typedef enum logic [1:0] {
    OP_DMUL = 2'd0,
    OP_DMLA = 2'd1,
    OP_DMLS = 2'd2,
    OP_RDMH = 2'd3
  } sdm_op_e;

  // doubled 16x16 product, {clip, value}
  function automatic logic [32:0] dmul16(input logic signed [15:0] a,
                                         input logic signed [15:0] b);
    logic signed [31:0] p;
    p = a * b;
    if (a == 16'sh8000 && b == 16'sh8000) return {1'b1, 32'h7FFF_FFFF};
    return {1'b0, p[30:0], 1'b0};
  endfunction

  // doubled 32x32 product, {clip, value}
  function automatic logic [64:0] dmul32(input logic signed [31:0] a,
                                         input logic signed [31:0] b);
    logic signed [63:0] p;
    p = a * b;
    if (a == 32'sh8000_0000 && b == 32'sh8000_0000)
      return {1'b1, 64'h7FFF_FFFF_FFFF_FFFF};
    return {1'b0, p[62:0], 1'b0};
  endfunction

  // saturating accumulate at 32 bits, overflow judged from signs
  function automatic logic [32:0] sacc32(input logic [31:0] acc,
                                         input logic [31:0] d,
                                         input logic sub);
    logic [31:0] s;
    logic ovf;
    s   = sub ? acc - d : acc + d;
    ovf = ((acc[31] ^ d[31]) == sub) && (s[31] != acc[31]);
    if (ovf) return {1'b1, acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
    return {1'b0, s};
  endfunction

  function automatic logic [64:0] sacc64(input logic [63:0] acc,
                                         input logic [63:0] d,
                                         input logic sub);
    logic [63:0] s;
    logic ovf;
    s   = sub ? acc - d : acc + d;
    ovf = ((acc[63] ^ d[63]) == sub) && (s[63] != acc[63]);
    if (ovf) return {1'b1, acc[63] ? 64'h8000_0000_0000_0000 : 64'h7FFF_FFFF_FFFF_FFFF};
    return {1'b0, s};
  endfunction

  // rounded high half of the doubled product, {clip, value}
  function automatic logic [16:0] rdmh16(input logic signed [15:0] a,
                                         input logic signed [15:0] b);
    logic signed [31:0] p;
    logic [32:0] t;
    p = a * b;
    t = {p, 1'b0} + 33'h0_0000_8000;
    if (a == 16'sh8000 && b == 16'sh8000) return {1'b1, 16'h7FFF};
    return {1'b0, t[31:16]};
  endfunction

  function automatic logic [32:0] rdmh32(input logic signed [31:0] a,
                                         input logic signed [31:0] b);
    logic signed [63:0] p;
    logic [64:0] t;
    p = a * b;
    t = {p, 1'b0} + 65'h0_0000_0000_8000_0000;
    if (a == 32'sh8000_0000 && b == 32'sh8000_0000) return {1'b1, 32'h7FFF_FFFF};
    return {1'b0, t[63:32]};
  endfunction

endpackage

// File: rtl/sdm_wide_lane.sv
module sdm_wide_lane
  import sdm_pkg::*;
(
  input  logic        esize,
  input  logic        acc_en,
  input  logic        sub,
  input  logic [31:0] a_chunk,
  input  logic [31:0] b_chunk,
  input  logic [63:0] acc,
  output logic [63:0] res,
  output logic        prod_sat,
  output logic        acc_sat
);

  logic [32:0] p_lo, p_hi, s_lo, s_hi;
  logic [64:0] p_w, s_w;

  always_comb begin
    p_lo = dmul16(a_chunk[15:0], b_chunk[15:0]);
    p_hi = dmul16(a_chunk[31:16], b_chunk[31:16]);
    p_w  = dmul32(a_chunk, b_chunk);
    s_lo = sacc32(acc[31:0], p_lo[31:0], sub);
    s_hi = sacc32(acc[63:32], p_hi[31:0], sub);
    s_w  = sacc64(acc, p_w[63:0], sub);
    if (esize) begin
      prod_sat = p_w[64];
      acc_sat  = acc_en & s_w[64];
      res      = acc_en ? s_w[63:0] : p_w[63:0];
    end else begin
      prod_sat = p_lo[32] | p_hi[32];
      acc_sat  = acc_en & (s_lo[32] | s_hi[32]);
      res      = acc_en ? {s_hi[31:0], s_lo[31:0]} : {p_hi[31:0], p_lo[31:0]};
    end
  end

endmodule

// File: rtl/sdm_rnd_lane.sv
module sdm_rnd_lane
  import sdm_pkg::*;
(
  input  logic        esize,
  input  logic [31:0] a_chunk,
  input  logic [31:0] b_chunk,
  output logic [31:0] res,
  output logic        sat
);

  logic [16:0] r_lo, r_hi;
  logic [32:0] r_w;

  always_comb begin
    r_lo = rdmh16(a_chunk[15:0], b_chunk[15:0]);
    r_hi = rdmh16(a_chunk[31:16], b_chunk[31:16]);
    r_w  = rdmh32(a_chunk, b_chunk);
    if (esize) begin
      res = r_w[31:0];
      sat = r_w[32];
    end else begin
      res = {r_hi[15:0], r_lo[15:0]};
      sat = r_lo[16] | r_hi[16];
    end
  end

endmodule

// File: rtl/sdm_unit.sv
module sdm_unit
  import sdm_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic             esize,
  input  logic             hi_sel,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  input  logic             sat_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_res,
  output logic             sat_flag
);

  localparam int HALF_W = VEC_W / 2;
  localparam int N_WIDE = VEC_W / 64;
  localparam int N_RND  = VEC_W / 32;

  logic [HALF_W-1:0] a_half, b_half;
  logic [VEC_W-1:0]  wide_res, rnd_res, res_next;
  logic [N_WIDE-1:0] prod_sat_v, acc_sat_v;
  logic [N_RND-1:0]  rnd_sat_v;
  logic              acc_en, acc_sub, is_rnd;
  // named events for the checker
  logic              prod_sat_any, acc_sat_any, rnd_sat_any, sat_event;

  assign a_half  = hi_sel ? src_a[VEC_W-1 -: HALF_W] : src_a[HALF_W-1:0];
  assign b_half  = hi_sel ? src_b[VEC_W-1 -: HALF_W] : src_b[HALF_W-1:0];
  assign is_rnd  = (sdm_op_e'(mode) == OP_RDMH);
  assign acc_en  = (sdm_op_e'(mode) == OP_DMLA) || (sdm_op_e'(mode) == OP_DMLS);
  assign acc_sub = (sdm_op_e'(mode) == OP_DMLS);

  for (genvar k = 0; k < N_WIDE; k++) begin : g_wide
    sdm_wide_lane u_wide (
      .esize    (esize),
      .acc_en   (acc_en),
      .sub      (acc_sub),
      .a_chunk  (a_half[32*k +: 32]),
      .b_chunk  (b_half[32*k +: 32]),
      .acc      (acc_in[64*k +: 64]),
      .res      (wide_res[64*k +: 64]),
      .prod_sat (prod_sat_v[k]),
      .acc_sat  (acc_sat_v[k])
    );
  end

  for (genvar j = 0; j < N_RND; j++) begin : g_rnd
    sdm_rnd_lane u_rnd (
      .esize   (esize),
      .a_chunk (src_a[32*j +: 32]),
      .b_chunk (src_b[32*j +: 32]),
      .res     (rnd_res[32*j +: 32]),
      .sat     (rnd_sat_v[j])
    );
  end

  assign prod_sat_any = |prod_sat_v;
  assign acc_sat_any  = |acc_sat_v;
  assign rnd_sat_any  = |rnd_sat_v;
  assign sat_event    = is_rnd ? rnd_sat_any : (prod_sat_any | acc_sat_any);
  assign res_next     = is_rnd ? rnd_res : wide_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_res <= res_next;
      sat_flag <= (sat_flag & ~sat_clr) | (in_valid & sat_event);
    end
  end

endmodule

// File: rtl/sdm_unit_chk.sv
module sdm_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       mode,
  input logic             esize,
  input logic             hi_sel,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] src_b,
  input logic             sat_clr,
  input logic             sat_event,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_res,
  input logic             sat_flag
);

  logic minmin16;
  assign minmin16 = (src_a[15:0] == 16'h8000) && (src_b[15:0] == 16'h8000);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_res)));

  // R11
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_event) |=> sat_flag);

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  // R11
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_flag) |-> $past(in_valid && sat_event));

  // R4
  minmin_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && !esize && !hi_sel && minmin16)
      |=> (out_res[31:0] == 32'h7FFF_FFFF && sat_flag));

  // R9
  rnd_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd3 && !esize && minmin16)
      |=> (out_res[15:0] == 16'h7FFF && sat_flag));

endmodule

bind sdm_unit sdm_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .esize     (esize),
  .hi_sel    (hi_sel),
  .src_a     (src_a),
  .src_b     (src_b),
  .sat_clr   (sat_clr),
  .sat_event (sat_event),
  .out_valid (out_valid),
  .out_res   (out_res),
  .sat_flag  (sat_flag)
);

// File: tb/sim_sdm_unit.sv
`timescale 1ns/1ps
module sim_sdm_unit;

  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         esize = 1'b0;
  logic         hi_sel = 1'b0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic [W-1:0] acc_in = '0;
  logic         sat_clr = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_res;
  logic         sat_flag;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic exp_flag = 1'b0;

  always #5 clk = ~clk;

  sdm_unit #(.VEC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .esize(esize),
    .hi_sel(hi_sel), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .sat_clr(sat_clr), .out_valid(out_valid), .out_res(out_res), .sat_flag(sat_flag)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] elem(input logic [W-1:0] v, input int pos,
                                               input int w);
    logic signed [W-1:0] t;
    t = v >> pos;
    for (int k = w; k < W; k++) t[k] = t[w-1];
    return t;
  endfunction

  // reference: wide signed arithmetic, then clamp by comparison
  function automatic void model(input logic [1:0] md, input logic es, input logic hi,
                                input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic [W-1:0] acc,
                                output logic [W-1:0] r, output logic s);
    logic signed [W-1:0] one, ea, eb, ec, p, lim_hi, lim_lo;
    logic [W-1:0] ha, hb;
    int ew, dw;
    one = 1;
    ew  = es ? 32 : 16;
    dw  = 2 * ew;
    r   = '0;
    s   = 1'b0;
    if (md == 2'd3) begin
      lim_hi = (one <<< (ew - 1)) - 1;
      lim_lo = -(one <<< (ew - 1));
      for (int i = 0; i < W / ew; i++) begin
        ea = elem(a, i * ew, ew);
        eb = elem(b, i * ew, ew);
        p  = (2 * ea * eb + (one <<< (ew - 1))) >>> ew;
        if (p > lim_hi) begin p = lim_hi; s = 1'b1; end
        if (p < lim_lo) begin p = lim_lo; s = 1'b1; end
        for (int k = 0; k < ew; k++) r[i * ew + k] = p[k];
      end
    end else begin
      ha = hi ? (a >> (W / 2)) : a;
      hb = hi ? (b >> (W / 2)) : b;
      lim_hi = (one <<< (dw - 1)) - 1;
      lim_lo = -(one <<< (dw - 1));
      for (int i = 0; i < (W / 2) / ew; i++) begin
        ea = elem(ha, i * ew, ew);
        eb = elem(hb, i * ew, ew);
        ec = elem(acc, i * dw, dw);
        p  = 2 * ea * eb;
        if (p > lim_hi) begin p = lim_hi; s = 1'b1; end
        if (md == 2'd1) p = ec + p;
        if (md == 2'd2) p = ec - p;
        if (p > lim_hi) begin p = lim_hi; s = 1'b1; end
        if (p < lim_lo) begin p = lim_lo; s = 1'b1; end
        for (int k = 0; k < dw; k++) r[i * dw + k] = p[k];
      end
    end
  endfunction

  // called at a falling edge; leaves the bench at the next falling edge
  task automatic run_op(input logic [1:0] md, input logic es, input logic hi,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] acc, input logic clr, input string req);
    logic [W-1:0] er;
    logic es_sat;
    model(md, es, hi, a, b, acc, er, es_sat);
    mode = md; esize = es; hi_sel = hi;
    src_a = a; src_b = b; acc_in = acc;
    sat_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; sat_clr = 1'b0;
    exp_flag = (exp_flag & ~clr) | es_sat;
    check(out_valid === 1'b1, {req, " valid"}, W'(out_valid), W'(1));
    check(out_res === er, {req, " result"}, out_res, er);
    check(sat_flag === exp_flag, {req, " flag"}, W'(sat_flag), W'(exp_flag));
  endtask

  task automatic clear_flag();
    sat_clr = 1'b1;
    @(negedge clk);
    sat_clr = 1'b0;
    exp_flag = 1'b0;
    check(sat_flag === 1'b0, "R11 clear", W'(sat_flag), W'(0));
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [W-1:0] held;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R12
    check(out_valid === 1'b0, "R12 valid", W'(out_valid), W'(0));
    check(out_res === '0, "R12 result", out_res, '0);
    check(sat_flag === 1'b0, "R12 flag", W'(sat_flag), W'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'd0, 1'b0, 1'b0, 128'h0, 128'h0000_0000_0000_0000_1234_FFFF_7FFF_0003,
           128'h0, 1'b0, "R1 zero a");
    run_op(2'd0, 1'b0, 1'b0, 128'h0, {64'h0, 16'h0005, 16'hFFFD, 16'h7FFF, 16'h7FFF},
           128'h0, 1'b0, "R1 mixed");
    run_op(2'd0, 1'b0, 1'b0, {64'h0, 16'h0005, 16'hFFFD, 16'h7FFF, 16'h7FFF},
           {64'h0, 16'h0005, 16'hFFFD, 16'h7FFF, 16'h7FFF}, 128'h0, 1'b0, "R1 squares");
    run_op(2'd0, 1'b1, 1'b0, {64'h0, 32'h8000_0001, 32'h7FFF_FFFF},
           {64'h0, 32'h8000_0001, 32'hFFFF_FFFE}, 128'h0, 1'b0, "R2 wide");
    run_op(2'd0, 1'b0, 1'b1, {64'h0001_0002_0003_0004, 64'hDEAD_BEEF_0000_1111},
           {64'h0010_0020_FFFF_0040, 64'h1234_5678_9ABC_DEF0}, 128'h0, 1'b0, "R3 upper");
    run_op(2'd0, 1'b0, 1'b0, {64'h0, 16'hC000, 16'h8000, 16'h8001, 16'h8000},
           {64'h0, 16'h8000, 16'hC000, 16'h8001, 16'h7FFF}, 128'h0, 1'b0, "R5 exact");
    run_op(2'd0, 1'b0, 1'b0, {64'h0, 48'h0, 16'h8000}, {64'h0, 48'h0, 16'h8000},
           128'h0, 1'b0, "R4 16-bit");
    clear_flag();
    run_op(2'd0, 1'b1, 1'b0, {64'h0, 32'h0, 32'h8000_0000},
           {64'h0, 32'h0, 32'h8000_0000}, 128'h0, 1'b0, "R4 32-bit");
    clear_flag();
    run_op(2'd1, 1'b0, 1'b0, {64'h0, 16'h0002, 16'h0003, 16'h7FFF, 16'h4000},
           {64'h0, 16'h0002, 16'h0003, 16'h7FFF, 16'h4000},
           {32'h0, 32'h8000_0000, 32'h7000_0000, 32'h7000_0000}, 1'b0, "R6 add");
    clear_flag();
    run_op(2'd2, 1'b0, 1'b0, {64'h0, 16'h0002, 16'h0003, 16'h7FFF, 16'h4000},
           {64'h0, 16'h0002, 16'h0003, 16'h7FFF, 16'h4000},
           {32'h7FFF_FFFF, 32'h0000_0005, 32'h9000_0000, 32'h0000_0000}, 1'b0, "R7 sub");
    clear_flag();
    run_op(2'd2, 1'b1, 1'b1, {32'h8000_0000, 32'h0001_0000, 64'h0},
           {32'h8000_0000, 32'h0001_0000, 64'h0},
           {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0, "R7 wide");
    clear_flag();
    run_op(2'd3, 1'b0, 1'b0, {16'h8001, 16'h4000, 16'h0001, 16'hFFFF, 16'h7FFF,
                              16'hC000, 16'h00FF, 16'h1234},
           {16'h8001, 16'h8000, 16'h4000, 16'hFFFF, 16'h7FFF,
            16'h8000, 16'h0101, 16'hEDCC}, 128'h0, 1'b0, "R8 round16");
    run_op(2'd3, 1'b1, 1'b0, {32'h8000_0001, 32'hC000_0000, 32'h0000_0001, 32'h1234_5678},
           {32'h8000_0001, 32'h8000_0000, 32'h4000_0000, 32'hEDCB_A988},
           128'h0, 1'b0, "R8 round32");
    run_op(2'd3, 1'b0, 1'b0, {112'h0, 16'h8000}, {112'h0, 16'h8000},
           128'h0, 1'b0, "R9 round clip");
    // R10: no operation accepted, result held
    held = out_res;
    @(negedge clk);
    check(out_valid === 1'b0, "R10 idle valid", W'(out_valid), W'(0));
    check(out_res === held, "R10 idle hold", out_res, held);
    check(sat_flag === 1'b1, "R11 sticky", W'(sat_flag), W'(1));
    clear_flag();
    run_op(2'd3, 1'b1, 1'b0, {96'h0, 32'h8000_0000}, {96'h0, 32'h8000_0000},
           128'h0, 1'b1, "R11 clear with set");

    for (int n = 0; n < 300; n++) begin
      logic [1:0]   md;
      logic         es;
      logic [W-1:0] a, b;
      md = 2'($urandom % 4);
      es = 1'($urandom % 2);
      a  = rnd128();
      b  = rnd128();
      if ($urandom % 4 == 0) begin
        if (es) begin a[31:0] = 32'h8000_0000; b[31:0] = 32'h8000_0000; end
        else begin a[15:0] = 16'h8000; b[15:0] = 16'h8000; end
      end
      run_op(md, es, 1'($urandom % 2), a, b, rnd128(), 1'($urandom % 8 == 0),
             md == 2'd3 ? "R8 random" : (md == 2'd0 ? (es ? "R2 random" : "R1 random")
                                          : (md == 2'd1 ? "R6 random" : "R7 random")));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule